// File: doc/BRIEF.md
# DRAM Command Execute Pipeline

This block is the final stage between a DRAM command scheduler and the memory pins. It runs on the full-rate DRAM clock but takes at most one command every second cycle, because its feeder runs at half that rate. Each accepted command moves down a fixed nine-stage timeline. Every command kind has a set stage for placing the command on the bus, for launching write data, for enabling the data strobe, for capturing read data and for reporting completion.

The feeder presents a command together with its address, request tag, two beats of write data and a per-beat byte mask. It must present them while `slot_open_o` is high. The block then drives the command, sequences the data and strobe for writes, and collects two read beats near the end of the line. It reports write completion and read completion with the matching tag on two separate outputs. These two completion outputs may be active in the same cycle. The DRAM side is modelled as plain registered ports. Pad delay is absorbed by choosing where in the timeline read data is captured.

Top module: `ddr_exec_pipe`

## Requirements
- R1: While reset is asserted, `dram_cmd_o` shows NOP (code 0), and all data, strobe and completion outputs are 0. `slot_open_o` is 1.
- R2: `slot_open_o` alternates every cycle after reset and starts at 1. A command is taken only at an edge where `slot_open_o` was 1. Input presented while it is 0 is ignored: no command, data or completion ever results from it.
- R3: A command taken at edge n shows on `dram_cmd_o`/`dram_addr_o` during the single cycle after that edge (stage 1). In every other cycle the bus shows NOP with address 0, so a non-NOP command is always followed by a NOP. Codes are: 0 NOP, 1 activate, 2 precharge, 3 refresh, 4 read, 5 write, 6 mode set.
- R4: A write launches its low data beat (`cmd_wdata_i` bits DW-1:0, mask bits MW-1:0) on `dq_o`/`dm_o` in stage 2 and its high beat in stage 3, with `dq_oe_o` high in both stages. At all other times these outputs are 0.
- R5: For a write, `dqs_oe_o` is high in stages 3 and 4 and low otherwise.
- R6: A write raises `wr_done_o` for one cycle in stage 7, with `wr_tag_o` equal to its tag. `wr_tag_o` is 0 when `wr_done_o` is low.
- R7: A read samples `rd_dq_i` at the end of stage 7 as the low beat and at the end of stage 8 as the high beat. Values on `rd_dq_i` in other cycles do not affect the result.
- R8: A read raises `rd_done_o` for one cycle in stage 9, with `rd_tag_o` equal to its tag and `rd_data_o` = {high beat, low beat}. Both are 0 when `rd_done_o` is low.
- R9: A read followed in the next slot by a write completes both in the same cycle, and each output carries its own tag.
- R10: Commands other than read and write, and NOPs, produce no data, strobe or completion activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate DRAM clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 3 | Command code |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_tag_i | input | TAG_W | Request tag |
| cmd_wdata_i | input | 2*DW | Write data, low beat first |
| cmd_mask_i | input | 2*MW | Byte mask, low beat first |
| slot_open_o | output | 1 | Next edge takes a command |
| dram_cmd_o | output | 3 | DRAM command bus |
| dram_addr_o | output | ADDR_W | DRAM address bus |
| dq_o | output | DW | Write data beat |
| dq_oe_o | output | 1 | Data output enable |
| dm_o | output | MW | Data mask beat |
| dqs_oe_o | output | 1 | Data strobe output enable |
| rd_dq_i | input | DW | Returning read data |
| wr_done_o | output | 1 | Write complete |
| wr_tag_o | output | TAG_W | Tag of completed write |
| rd_done_o | output | 1 | Read complete |
| rd_tag_o | output | TAG_W | Tag of completed read |
| rd_data_o | output | 2*DW | Read data of completed read |

## Verification
A read followed by a write in the next slot lands write completion (stage 7) and read completion (stage 9) in the same cycle. The same happens with the strobe of one write and the data launch of the next. The bench issues every ordered pair of command codes back to back, which provokes each such overlap. It predicts every output in every cycle from per-command stage offsets. A coinciding completion passes only if both tags and the read data are each correct. The read input carries distinct noise in every cycle, so a capture in the wrong stage shows up as a data mismatch.

// File: rtl/ddr_exec_pkg.sv
package ddr_exec_pkg;
  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_ACT = 3'd1;
  localparam logic [2:0] OP_PRE = 3'd2;
  localparam logic [2:0] OP_REF = 3'd3;
  localparam logic [2:0] OP_RD  = 3'd4;
  localparam logic [2:0] OP_WR  = 3'd5;
  localparam logic [2:0] OP_MRS = 3'd6;
endpackage

// File: rtl/ddr_exec_slot.sv
module ddr_exec_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic open_o,
  output logic take_o
);
  logic odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) odd_q <= 1'b0;
    else         odd_q <= ~odd_q;
  end

  assign open_o = ~odd_q;
  assign take_o = valid_i & ~odd_q;
endmodule

// File: rtl/ddr_exec_shift.sv
module ddr_exec_shift #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o [DEPTH]
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     q_o[k] <= '0;
      else if (k == 0) q_o[k] <= d_i;
      else             q_o[k] <= q_o[(k == 0) ? 0 : k-1];
    end
  end
endmodule

// File: rtl/ddr_exec_rdcap.sv
module ddr_exec_rdcap #(
  parameter int unsigned DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_lo_i,
  input  logic            cap_hi_i,
  input  logic [DW-1:0]   dq_i,
  output logic [2*DW-1:0] data_o
);
  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo_i) lo_q <= dq_i;
      if (cap_hi_i) hi_q <= dq_i;
    end
  end

  assign data_o = {hi_q, lo_q};
endmodule

// File: rtl/ddr_exec_pipe.sv
module ddr_exec_pipe
  import ddr_exec_pkg::*;
#(
  parameter int unsigned DW           = 16,
  parameter int unsigned MW           = DW / 8,
  parameter int unsigned TAG_W        = 4,
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned WR_LAUNCH_ST = 2,
  parameter int unsigned WR_DONE_ST   = 7,
  parameter int unsigned RD_CAP_ST    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [TAG_W-1:0]  cmd_tag_i,
  input  logic [2*DW-1:0]   cmd_wdata_i,
  input  logic [2*MW-1:0]   cmd_mask_i,
  output logic              slot_open_o,
  output logic [2:0]        dram_cmd_o,
  output logic [ADDR_W-1:0] dram_addr_o,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o,
  output logic [MW-1:0]     dm_o,
  output logic              dqs_oe_o,
  input  logic [DW-1:0]     rd_dq_i,
  output logic              wr_done_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic              rd_done_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [2*DW-1:0]   rd_data_o
);
  localparam int unsigned DQS_ST     = WR_LAUNCH_ST + 1;
  localparam int unsigned RD_DONE_ST = RD_CAP_ST + 2;
  localparam int unsigned DEPTH      = (RD_DONE_ST > WR_DONE_ST) ? RD_DONE_ST : WR_DONE_ST;

  typedef struct packed {
    logic              vld;
    logic [2:0]        op;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] addr;
    logic [2*DW-1:0]   wdata;
    logic [2*MW-1:0]   mask;
  } stg_t;
  localparam int unsigned SW = $bits(stg_t);

  logic take;
  stg_t in_s;
  logic [SW-1:0] pipe [DEPTH];
  stg_t st [DEPTH];
  logic [DEPTH-1:0] is_rd, is_wr;

  ddr_exec_slot u_slot (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(cmd_valid_i),
    .open_o (slot_open_o),
    .take_o (take)
  );

  always_comb begin
    in_s = '0;
    if (take && cmd_op_i != OP_NOP) begin
      in_s.vld   = 1'b1;
      in_s.op    = cmd_op_i;
      in_s.tag   = cmd_tag_i;
      in_s.addr  = cmd_addr_i;
      in_s.wdata = cmd_wdata_i;
      in_s.mask  = cmd_mask_i;
    end
  end

  ddr_exec_shift #(.W(SW), .DEPTH(DEPTH)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (in_s),
    .q_o   (pipe)
  );

  for (genvar k = 0; k < DEPTH; k++) begin : g_dec
    assign st[k]    = stg_t'(pipe[k]);
    assign is_rd[k] = st[k].vld && st[k].op == OP_RD;
    assign is_wr[k] = st[k].vld && st[k].op == OP_WR;
  end

  // stage s lives in st[s-1]
  assign dram_cmd_o  = st[0].vld ? st[0].op   : OP_NOP;
  assign dram_addr_o = st[0].vld ? st[0].addr : '0;

  always_comb begin
    dq_o = '0;
    dm_o = '0;
    if (is_wr[WR_LAUNCH_ST-1]) begin
      dq_o = st[WR_LAUNCH_ST-1].wdata[DW-1:0];
      dm_o = st[WR_LAUNCH_ST-1].mask[MW-1:0];
    end else if (is_wr[WR_LAUNCH_ST]) begin
      dq_o = st[WR_LAUNCH_ST].wdata[2*DW-1:DW];
      dm_o = st[WR_LAUNCH_ST].mask[2*MW-1:MW];
    end
  end
  assign dq_oe_o  = is_wr[WR_LAUNCH_ST-1] | is_wr[WR_LAUNCH_ST];
  assign dqs_oe_o = is_wr[DQS_ST-1] | is_wr[DQS_ST];

  assign wr_done_o = is_wr[WR_DONE_ST-1];
  assign wr_tag_o  = wr_done_o ? st[WR_DONE_ST-1].tag : '0;

  logic [2*DW-1:0] cap_data;
  ddr_exec_rdcap #(.DW(DW)) u_rdcap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_lo_i(is_rd[RD_CAP_ST-1]),
    .cap_hi_i(is_rd[RD_CAP_ST]),
    .dq_i    (rd_dq_i),
    .data_o  (cap_data)
  );

  assign rd_done_o = is_rd[RD_DONE_ST-1];
  assign rd_tag_o  = rd_done_o ? st[RD_DONE_ST-1].tag : '0;
  assign rd_data_o = rd_done_o ? cap_data : '0;
endmodule

// File: rtl/ddr_exec_pipe_chk.sv
module ddr_exec_pipe_chk #(
  parameter int unsigned WR_DONE_ST = 7,
  parameter int unsigned RD_DONE_ST = 9
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       slot_open_o,
  input logic [2:0] dram_cmd_o,
  input logic       dq_oe_o,
  input logic       dqs_oe_o,
  input logic       wr_done_o,
  input logic       rd_done_o
);
  assert_half_rate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_cmd_o != 3'd0) |=> (dram_cmd_o == 3'd0));

  assert_issue_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dram_cmd_o != 3'd0) |-> !slot_open_o);

  assert_strobe_follows_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dqs_oe_o) |-> (dq_oe_o && $past(dq_oe_o)));

  assert_wr_done_stage_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> ($past(dram_cmd_o, WR_DONE_ST-1) == 3'd5));

  assert_rd_done_stage_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |-> ($past(dram_cmd_o, RD_DONE_ST-1) == 3'd4));
endmodule

bind ddr_exec_pipe ddr_exec_pipe_chk #(
  .WR_DONE_ST(WR_DONE_ST),
  .RD_DONE_ST(RD_DONE_ST)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .slot_open_o(slot_open_o),
  .dram_cmd_o (dram_cmd_o),
  .dq_oe_o    (dq_oe_o),
  .dqs_oe_o   (dqs_oe_o),
  .wr_done_o  (wr_done_o),
  .rd_done_o  (rd_done_o)
);

// File: tb/tb_ddr_exec_pipe.sv
module tb_ddr_exec_pipe;
  localparam int DW = 16, MW = 2, TAG_W = 4, ADDR_W = 13;
  localparam int NC = 1024;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [TAG_W-1:0] cmd_tag = '0;
  logic [2*DW-1:0] cmd_wdata = '0;
  logic [2*MW-1:0] cmd_mask = '0;
  logic [DW-1:0] rd_dq = '0;
  logic slot_open, dq_oe, dqs_oe, wr_done, rd_done;
  logic [2:0] dram_cmd;
  logic [ADDR_W-1:0] dram_addr;
  logic [DW-1:0] dq;
  logic [MW-1:0] dm;
  logic [TAG_W-1:0] wr_tag, rd_tag;
  logic [2*DW-1:0] rd_data;

  ddr_exec_pipe dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_tag_i(cmd_tag), .cmd_wdata_i(cmd_wdata),
    .cmd_mask_i(cmd_mask), .slot_open_o(slot_open), .dram_cmd_o(dram_cmd),
    .dram_addr_o(dram_addr), .dq_o(dq), .dq_oe_o(dq_oe), .dm_o(dm),
    .dqs_oe_o(dqs_oe), .rd_dq_i(rd_dq), .wr_done_o(wr_done), .wr_tag_o(wr_tag),
    .rd_done_o(rd_done), .rd_tag_o(rd_tag), .rd_data_o(rd_data)
  );

  always #5 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  bit running = 1'b0, finished = 1'b0;
  logic [2:0] e_cmd [NC];
  logic [ADDR_W-1:0] e_addr [NC];
  logic [DW-1:0] e_dq [NC];
  logic [MW-1:0] e_dm [NC];
  logic e_oe [NC], e_dqs [NC], e_wd [NC], e_rd [NC];
  logic [TAG_W-1:0] e_wt [NC], e_rt [NC];
  logic [2*DW-1:0] e_rdat [NC];

  function automatic logic [DW-1:0] noise(int m);
    return DW'(m * 37) ^ 16'hA5A5;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) rd_dq <= noise(cyc);

  task automatic chk(string rq, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", rq, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && cyc < NC) begin
      chk("R3 cmd", dram_cmd, e_cmd[cyc]);
      chk("R3 addr", dram_addr, e_addr[cyc]);
      chk("R4 dq", {dq_oe, dm, dq}, {e_oe[cyc], e_dm[cyc], e_dq[cyc]});
      chk("R5 dqs", dqs_oe, e_dqs[cyc]);
      chk("R6 wr_done", {wr_done, wr_tag}, {e_wd[cyc], e_wt[cyc]});
      chk("R8 rd_done", {rd_done, rd_tag, rd_data}, {e_rd[cyc], e_rt[cyc], e_rdat[cyc]});
    end
  end

  // wait for an open slot, drive, predict from stage offsets
  task automatic issue(logic [2:0] op, logic [ADDR_W-1:0] a, logic [TAG_W-1:0] t,
                       logic [2*DW-1:0] wd, logic [2*MW-1:0] mk);
    int n;
    @(negedge clk);
    while (!slot_open) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_tag = t;
    cmd_wdata = wd; cmd_mask = mk;
    n = cyc + 1;
    if (op != 3'd0 && n + 9 < NC) begin
      e_cmd[n] = op; e_addr[n] = a;
      if (op == 3'd5) begin  // R4 R5 R6
        e_oe[n+1] = 1'b1; e_dq[n+1] = wd[DW-1:0];     e_dm[n+1] = mk[MW-1:0];
        e_oe[n+2] = 1'b1; e_dq[n+2] = wd[2*DW-1:DW];  e_dm[n+2] = mk[2*MW-1:MW];
        e_dqs[n+2] = 1'b1; e_dqs[n+3] = 1'b1;
        e_wd[n+6] = 1'b1; e_wt[n+6] = t;
      end
      if (op == 3'd4) begin  // R7 R8
        e_rd[n+8] = 1'b1; e_rt[n+8] = t;
        e_rdat[n+8] = {noise(n+7), noise(n+6)};
      end
    end
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin
      e_cmd[i] = '0; e_addr[i] = '0; e_dq[i] = '0; e_dm[i] = '0; e_oe[i] = 0;
      e_dqs[i] = 0; e_wd[i] = 0; e_rd[i] = 0; e_wt[i] = '0; e_rt[i] = '0; e_rdat[i] = '0;
    end
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 idle", {dram_cmd, dram_addr, dq, dq_oe, dm, dqs_oe}, 0);
    chk("R1 done", {wr_done, wr_tag, rd_done, rd_tag, rd_data}, 0);
    chk("R1 slot", slot_open, 1);
    rst_ni = 1'b1;
    running = 1'b1;
    @(negedge clk);
    chk("R2 slot alt", slot_open, 0);
    @(negedge clk);
    chk("R2 slot alt", slot_open, 1);
    // R9 R10: every ordered pair of codes back to back
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++) begin
        issue(3'(a), ADDR_W'(a * 131 + b), TAG_W'(a + b), 32'h1111_0000 * (a + 1) + 32'(b),
              4'(a ^ b));
        issue(3'(b), ADDR_W'(b * 17 + a + 1), TAG_W'(b * 3 + 1), 32'h0101_0101 * (b + 2),
              4'(b + 1));
      end
    // R2 input in a closed slot is ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      while (slot_open) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = (k[0]) ? 3'd4 : 3'd5; cmd_tag = 4'hF;
      cmd_wdata = 32'hDEAD_BEEF; cmd_mask = 4'hF;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    repeat (14) @(negedge clk);
    running = 1'b0;
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule